// File: doc/BRIEF.md
# SDRAM Command Front End

This block is the command decoder at the front of a four-bank SDRAM device model. On every rising clock edge it samples chip select, the three active-low command pins (row strobe, column strobe, write enable), two bank-select pins, a 12-bit address bus and the clock-enable pin. It turns each accepted pin pattern into a one-cycle command strobe and reports the bank index, the row or column value and the qualifier flags that go with that command.

The block also keeps per-bank state: whether a row is open and which row it is. Illegal accesses raise an error pulse instead of a strobe. Examples are a burst to an idle bank and an activate to a bank whose row is already open. A read or write with the auto-precharge flag closes its bank on its own once the burst window has run out. Clock enable is filtered so that a level shorter than one full cycle never changes the power state. While the block is powered down, commands are ignored.

All outputs are registered. The result of the command sampled at edge k is visible just after edge k. The data path, strobe timing and burst data transfer belong to other blocks.

Top module: `sdram_cmd_front`

## Requirements
- R1: Command pins are read as {ras_n, cas_n, we_n}. The patterns are 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode-register set. 111 and 110 are no-operation. An accepted command raises exactly one strobe for one cycle, just after the edge that sampled it.
- R2: A command sampled with cs_n high produces no strobe and no error. An auto-precharge countdown that has already started still runs to completion.
- R3: The bank index is 2*bsel_a + bsel_b. That is: bsel_a=0 with bsel_b=0 gives bank 0, bsel_a=0 with bsel_b=1 gives bank 1, bsel_a=1 with bsel_b=0 gives bank 2, and bsel_a=1 with bsel_b=1 gives bank 3. bank_o shows this index with every activate, read, write and precharge strobe.
- R4: An activate to an idle bank stores all 12 address bits as that bank's row, sets the bank's open_mask_o bit and shows the row on row_o.
- R5: A read or write shows addr[9:0] on col_o as the burst start column and the bank's stored row on row_o. auto_pre_o is set to addr[10] for that one cycle.
- R6: A precharge with addr[10]=1 closes every bank and sets pre_all_o. With addr[10]=0 it closes only the addressed bank and leaves pre_all_o low.
- R7: After a read or write with addr[10]=1 at edge k, the bank's open_mask_o bit clears at edge k+BURST_LEN (default 4).
- R8: A read or write to a bank with no open row raises err_o for one cycle and raises no strobe.
- R9: An activate to a bank with an open row raises err_o, raises no strobe and keeps the stored row.
- R10: power_down_o rises after cke is sampled low at two consecutive edges. It falls after cke is sampled high at two consecutive edges. A level seen at only one edge has no effect.
- R11: A command is accepted only when power_down_o is low before the edge and cke is high at that edge. Otherwise it produces no strobe and no error.
- R12: Directly after reset, all strobes, err_o, auto_pre_o, pre_all_o, open_mask_o and power_down_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| bsel_a | input | 1 | Bank select pin, weight 2 |
| bsel_b | input | 1 | Bank select pin, weight 1 |
| addr | input | 12 | Row / column / flag address bus |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| ref_o | output | 1 | Refresh strobe |
| mrs_o | output | 1 | Mode-register set strobe |
| bank_o | output | 2 | Bank of the last bank command |
| row_o | output | 12 | Row of the last activate, read or write |
| col_o | output | 10 | Burst start column of the last read or write |
| auto_pre_o | output | 1 | Auto-precharge flag, valid with rd_o/wr_o |
| pre_all_o | output | 1 | All-bank flag, valid with pre_o |
| err_o | output | 1 | Illegal-access pulse |
| open_mask_o | output | 4 | One bit per bank, set while a row is open |
| power_down_o | output | 1 | Powered-down state |

## Verification
Several properties are checked on every cycle. At most one strobe is active at a time. Bursts and activates are always consistent with the open-row mask, and an activate is never accepted onto a bank that was already open. A global precharge leaves no bank open. Chip select high and the powered-down state silence all strobes and errors. A power-down entry is always preceded by two low clock-enable samples. The bench scenarios are needed for the values themselves: the bank pin mapping, the row and column captured, the row kept after a refused activate, the exact cycle at which auto-precharge closes a bank, and the rejection of one-cycle clock-enable pulses.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  // Pin pattern {ras_n, cas_n, we_n} to command.
  function automatic cmd_e decode_pins(input logic r_n, input logic c_n, input logic w_n);
    cmd_e res;
    case ({r_n, c_n, w_n})
      3'b011:  res = CMD_ACT;
      3'b101:  res = CMD_RD;
      3'b100:  res = CMD_WR;
      3'b010:  res = CMD_PRE;
      3'b001:  res = CMD_REF;
      3'b000:  res = CMD_MRS;
      default: res = CMD_NOP;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sdcmd_cke_gate.sv
`timescale 1ns/1ps
// Clock-enable qualifier: a level counts only once it is seen at two
// consecutive rising edges.
module sdcmd_cke_gate (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  output logic cke_ok_o
);
  logic last_q;
  logic ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      ok_q   <= 1'b1;
    end else begin
      last_q <= cke;
      if (cke == last_q) ok_q <= cke;
    end
  end

  assign cke_ok_o = ok_q;
endmodule

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
// Combinational command decode and legality check against bank state.
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke_now,
  input  logic                 cke_ok,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] open_mask,
  output cmd_e                 cmd_o,
  output logic                 err_o
);
  cmd_e raw;
  logic taken;
  logic bank_open;

  always_comb begin
    taken     = !cs_n && cke_now && cke_ok;
    raw       = taken ? decode_pins(ras_n, cas_n, we_n) : CMD_NOP;
    bank_open = open_mask[bank];
    err_o     = ((raw == CMD_RD || raw == CMD_WR) && !bank_open) ||
                ((raw == CMD_ACT) && bank_open);
    cmd_o     = err_o ? CMD_NOP : raw;
  end
endmodule

// File: rtl/sdcmd_bank_table.sv
`timescale 1ns/1ps
// Per-bank open flag, stored row and auto-precharge countdown.
module sdcmd_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       act_en,
  input  logic                       ap_en,
  input  logic                       close_en,
  input  logic                       close_all,
  input  logic [BANK_W-1:0]          bank,
  input  logic [ROW_W-1:0]           row_in,
  output logic [NUM_BANKS-1:0]       open_mask_o,
  output logic [NUM_BANKS*ROW_W-1:0] row_flat_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = (bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q <= 1'b0;
        row_q  <= '0;
        cnt_q  <= '0;
      end else if (close_en && (close_all || hit)) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else if (act_en && hit) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end else if (ap_en && hit) begin
        cnt_q  <= CNT_W'(BURST_LEN);
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) open_q <= 1'b0;
      end
    end

    assign open_mask_o[g]                  = open_q;
    assign row_flat_o[g*ROW_W +: ROW_W]    = row_q;
  end
endmodule

// File: rtl/sdram_cmd_front.sv
`timescale 1ns/1ps
module sdram_cmd_front
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              bsel_a,
  input  logic              bsel_b,
  input  logic [ADDR_W-1:0] addr,
  output logic              act_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              pre_o,
  output logic              ref_o,
  output logic              mrs_o,
  output logic [1:0]        bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              auto_pre_o,
  output logic              pre_all_o,
  output logic              err_o,
  output logic [3:0]        open_mask_o,
  output logic              power_down_o
);
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  logic                        cke_ok;
  logic [BANK_W-1:0]           bank;
  cmd_e                        cmd;
  logic                        bad;
  logic [NUM_BANKS-1:0]        open_mask;
  logic [NUM_BANKS*ADDR_W-1:0] row_flat;
  logic                        burst;

  assign bank  = {bsel_a, bsel_b};
  assign burst = (cmd == CMD_RD) || (cmd == CMD_WR);

  sdcmd_cke_gate u_cke (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .cke_ok_o (cke_ok)
  );

  sdcmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cke_now   (cke),
    .cke_ok    (cke_ok),
    .bank      (bank),
    .open_mask (open_mask),
    .cmd_o     (cmd),
    .err_o     (bad)
  );

  sdcmd_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ADDR_W),
    .BURST_LEN (BURST_LEN)
  ) u_banks (
    .clk         (clk),
    .rst         (rst),
    .act_en      (cmd == CMD_ACT),
    .ap_en       (burst && addr[AP_BIT]),
    .close_en    (cmd == CMD_PRE),
    .close_all   (addr[AP_BIT]),
    .bank        (bank),
    .row_in      (addr),
    .open_mask_o (open_mask),
    .row_flat_o  (row_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o      <= 1'b0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
      pre_o      <= 1'b0;
      ref_o      <= 1'b0;
      mrs_o      <= 1'b0;
      err_o      <= 1'b0;
      auto_pre_o <= 1'b0;
      pre_all_o  <= 1'b0;
      bank_o     <= '0;
      row_o      <= '0;
      col_o      <= '0;
    end else begin
      act_o      <= (cmd == CMD_ACT);
      rd_o       <= (cmd == CMD_RD);
      wr_o       <= (cmd == CMD_WR);
      pre_o      <= (cmd == CMD_PRE);
      ref_o      <= (cmd == CMD_REF);
      mrs_o      <= (cmd == CMD_MRS);
      err_o      <= bad;
      auto_pre_o <= burst && addr[AP_BIT];
      pre_all_o  <= (cmd == CMD_PRE) && addr[AP_BIT];
      if (cmd == CMD_ACT || cmd == CMD_PRE || burst) bank_o <= bank;
      if (cmd == CMD_ACT) row_o <= addr;
      if (burst) begin
        row_o <= row_flat[bank*ADDR_W +: ADDR_W];
        col_o <= addr[COL_W-1:0];
      end
    end
  end

  assign open_mask_o  = open_mask;
  assign power_down_o = !cke_ok;
endmodule

// File: rtl/sdram_cmd_front_chk.sv
`timescale 1ns/1ps
module sdram_cmd_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       act_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic       pre_o,
  input logic       ref_o,
  input logic       mrs_o,
  input logic [1:0] bank_o,
  input logic       pre_all_o,
  input logic       err_o,
  input logic [3:0] open_mask_o,
  input logic       power_down_o
);
  logic [5:0] stb;
  assign stb = {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o};

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  assert_cs_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (stb == 6'b0 && !err_o));

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (rst)
    act_o |-> open_mask_o[bank_o]);

  assert_burst_needs_row_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> open_mask_o[bank_o]);

  assert_err_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !(act_o || rd_o || wr_o));

  assert_act_was_idle_R9: assert property (@(posedge clk) disable iff (rst)
    act_o |-> ((($past(open_mask_o)) >> bank_o) & 4'b0001) == 4'b0000);

  assert_pre_all_R6: assert property (@(posedge clk) disable iff (rst)
    (pre_o && pre_all_o) |-> (open_mask_o == 4'b0000));

  assert_pd_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(power_down_o) |-> (!$past(cke) && !$past(cke, 2)));

  assert_pd_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    power_down_o |-> (stb == 6'b0 && !err_o));
endmodule

bind sdram_cmd_front sdram_cmd_front_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cke          (cke),
  .cs_n         (cs_n),
  .act_o        (act_o),
  .rd_o         (rd_o),
  .wr_o         (wr_o),
  .pre_o        (pre_o),
  .ref_o        (ref_o),
  .mrs_o        (mrs_o),
  .bank_o       (bank_o),
  .pre_all_o    (pre_all_o),
  .err_o        (err_o),
  .open_mask_o  (open_mask_o),
  .power_down_o (power_down_o)
);

// File: tb/sdram_cmd_front_test.sv
`timescale 1ns/1ps
module sdram_cmd_front_test;
  localparam int BL = 4;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                         C_NOP = 3'b111;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic bsel_a = 1'b0, bsel_b = 1'b0;
  logic [11:0] addr = '0;
  logic act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, auto_pre_o, pre_all_o, err_o, power_down_o;
  logic [1:0] bank_o;
  logic [11:0] row_o;
  logic [9:0] col_o;
  logic [3:0] open_mask_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model of the block's visible state
  bit        m_open [4];
  logic [11:0] m_row [4];
  int        m_cnt  [4];
  bit        m_last = 1, m_ok = 1;

  always #4 clk = ~clk;

  sdram_cmd_front uut (.*);

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic cke_v, logic cs_v, logic [2:0] rcw,
                      logic [1:0] bk, logic [11:0] a);
    bit acc, is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, e_err;
    logic [5:0] e_stb;
    logic [11:0] e_row;
    @(negedge clk);
    cke = cke_v; cs_n = cs_v; {ras_n, cas_n, we_n} = rcw;
    bsel_a = bk[1]; bsel_b = bk[0]; addr = a;
    acc    = m_ok && cke_v && !cs_v;
    is_act = acc && rcw == C_ACT;
    is_rd  = acc && rcw == C_RD;
    is_wr  = acc && rcw == C_WR;
    is_pre = acc && rcw == C_PRE;
    is_ref = acc && rcw == C_REF;
    is_mrs = acc && rcw == C_MRS;
    e_err  = ((is_rd || is_wr) && !m_open[bk]) || (is_act && m_open[bk]);
    if (e_err) begin is_act = 0; is_rd = 0; is_wr = 0; end
    e_stb  = {is_act, is_rd, is_wr, is_pre, is_ref, is_mrs};
    e_row  = is_act ? a : m_row[bk];
    for (int b = 0; b < 4; b++) begin
      if (is_pre && (a[10] || b == bk)) begin m_open[b] = 0; m_cnt[b] = 0; end
      else if (is_act && b == bk) begin m_open[b] = 1; m_row[b] = a; end
      else if ((is_rd || is_wr) && a[10] && b == bk) m_cnt[b] = BL;
      else if (m_cnt[b] != 0) begin
        m_cnt[b]--;
        if (m_cnt[b] == 0) m_open[b] = 0;
      end
    end
    if (cke_v == m_last) m_ok = cke_v;
    m_last = cke_v;
    @(posedge clk); #1;
    check(tag, "strobes/err/flags/mask/pd",
          {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, err_o, auto_pre_o, pre_all_o, open_mask_o, power_down_o},
          {e_stb, e_err, (is_rd || is_wr) && a[10], is_pre && a[10],
           m_open[3], m_open[2], m_open[1], m_open[0], !m_ok});
    if (is_act || is_rd || is_wr || is_pre) check(tag, "bank_o", bank_o, bk);
    if (is_act || is_rd || is_wr) check(tag, "row_o", row_o, e_row);
    if (is_rd || is_wr) check(tag, "col_o", col_o, a[9:0]);
  endtask

  task automatic cmd(string tag, logic [2:0] rcw, logic [1:0] bk, logic [11:0] a);
    step(tag, 1'b1, 1'b0, rcw, bk, a);
  endtask

  task automatic nop(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, C_NOP, 2'd0, 12'h000);
  endtask

  task automatic run_all;
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; m_cnt[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R12: state straight after reset
    check("R12", "reset outputs",
          {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, err_o, auto_pre_o, pre_all_o, open_mask_o, power_down_o},
          14'b0);

    // R1: every pin pattern on bank 0 in turn
    for (int p = 0; p < 8; p++) cmd("R1", p[2:0], 2'd0, 12'h040);
    cmd("R6", C_PRE, 2'd0, 12'h400);

    // R3 / R4: open every bank with a distinct row
    for (int b = 0; b < 4; b++) cmd("R3", C_ACT, b[1:0], 12'h3C5 + 12'h211 * b);
    for (int b = 0; b < 4; b++) cmd("R4", C_RD, b[1:0], 12'h001 + b);

    // R9: second activate to an open bank is refused, row kept
    cmd("R9", C_ACT, 2'd2, 12'hFFF);
    cmd("R9", C_RD, 2'd2, 12'h155);

    // R5: column sweep, reads and writes, no auto-precharge
    for (int c = 0; c < 16; c++)
      cmd("R5", (c % 2) ? C_WR : C_RD, c[1:0], {2'b00, 10'((c * 67) % 1024)});
    cmd("R5", C_WR, 2'd3, 12'h3FF);
    cmd("R5", C_RD, 2'd1, 12'h000);

    // R6: single-bank then all-bank precharge
    cmd("R6", C_PRE, 2'd1, 12'h3FF);
    cmd("R6", C_PRE, 2'd2, 12'h400);

    // R8: bursts to idle banks
    for (int b = 0; b < 4; b++) cmd("R8", (b % 2) ? C_WR : C_RD, b[1:0], 12'h010);

    // R7: auto-precharge closes the bank after the burst window
    cmd("R7", C_ACT, 2'd1, 12'hABC);
    cmd("R7", C_WR, 2'd1, 12'h422);
    nop("R7", BL + 1);
    cmd("R7", C_ACT, 2'd2, 12'h123);
    cmd("R7", C_RD, 2'd2, 12'h7FF);
    // R2: chip select high mid-countdown; countdown keeps running
    for (int i = 0; i < BL + 1; i++) step("R2", 1'b1, 1'b1, C_ACT, 2'd0, 12'h555);
    step("R2", 1'b1, 1'b1, C_PRE, 2'd3, 12'h400);
    cmd("R2", C_ACT, 2'd3, 12'h0F0);

    // R10 / R11: one-edge clock-enable pulses are ignored
    step("R10", 1'b0, 1'b0, C_ACT, 2'd0, 12'h111);
    cmd("R10", C_ACT, 2'd0, 12'h222);
    for (int i = 0; i < 3; i++) step("R11", 1'b0, 1'b0, C_PRE, 2'd3, 12'h400);
    step("R10", 1'b1, 1'b0, C_PRE, 2'd3, 12'h400);
    step("R10", 1'b0, 1'b0, C_PRE, 2'd3, 12'h400);
    step("R10", 1'b1, 1'b0, C_PRE, 2'd3, 12'h400);
    step("R11", 1'b1, 1'b0, C_PRE, 2'd3, 12'h400);
    cmd("R11", C_PRE, 2'd3, 12'h000);
    cmd("R11", C_REF, 2'd0, 12'h000);
    nop("R1", 2);
  endtask

  initial begin
    fork
      begin run_all(); done = 1; end
      begin #(8 * 200000); end
    join_any
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule